// File: doc/BRIEF.md
# Byte-Parity Protected RAM with Error Injection

This block wraps a synchronous single-port RAM and stores one parity bit next to every data byte. The data path is 16 byte lanes wide. Each request cycle is either a read or a byte-enabled write. A read returns its data one cycle later, together with a response-error flag. On a write, every enabled lane stores its parity in the sense chosen for that lane: even by default, or odd when software asks for it. Reads always check for even parity. Writing a lane with odd parity is therefore a controlled way to inject a fault that the checker will find.

A small register port has two registers. The control register holds the per-lane parity sense, a global check-disable bit, a response-error enable and three interrupt enables. The status register holds three sticky flags, each cleared by writing 1 to it: single-lane error, multi-lane error and locked-access seen. One level-sensitive interrupt line reports any flag whose enable is set. Software can also leave all interrupts disabled and poll the status register instead.

Top module: `parity_ram`

## Requirements
- R1: A write stores `req_wdata` only in lanes whose `req_be` bit is 1, and leaves the other lanes unchanged. A read returns its data on `rsp_rdata` with `rsp_valid` high exactly one cycle after the request. A write produces no `rsp_valid`.
- R2: Control bits [15:0] select the parity sense per lane: bit i covers data bits [8i+7:8i], 0 means even and 1 means odd. The sense is fixed at write time. Reads always check even parity, so a lane written odd fails on every later read.
- R3: When checking is enabled, a read with exactly one failing lane sets status bit 0 (single error). A read with two or more failing lanes sets status bit 1 (multi error). The flags are logged even when every interrupt enable is 0.
- R4: When control bit 16 (check disable) is 1, a read produces no status update, no `rsp_err` and no parity interrupt, whatever the stored parity.
- R5: `rsp_err` is 1 in the response cycle only when control bit 17 is 1, checking is enabled and at least one lane fails. Otherwise the response is OK.
- R6: `irq` equals the OR over the three flags of (status bit 0 AND control bit 18), (status bit 1 AND control bit 19) and (status bit 2 AND control bit 20). It stays high until the flag is cleared.
- R7: A request with `req_lock` high, whether read or write, sets status bit 2 from the next cycle on. This happens even when checking is disabled.
- R8: Writing the status register (`reg_sel`=1) clears each flag whose write-data bit is 1. A flag being set in the same cycle wins over the clear.
- R9: After reset, both registers read 0, `irq` is 0 and `rsp_valid` is 0. Control bits [31:21] always read 0.
- R10: Parity status and `irq` show a read's error in the same cycle as its response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_lock | input | 1 | Locked-access marker on the request |
| req_addr | input | AW | Word address |
| req_be | input | 16 | Per-lane write enable |
| req_wdata | input | 128 | Write data |
| rsp_valid | output | 1 | Read data returned this cycle |
| rsp_rdata | output | 128 | Read data |
| rsp_err | output | 1 | Error response for this read |
| reg_sel | input | 1 | 0 control, 1 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong stored parity bit or a wrong lane count shows up at the ports in the response cycle of the next read of that word. It appears as the wrong status flag, a wrong `rsp_err` or a wrong `irq`. A flag that is sticky when it should clear, or that clears when it should stay, shows up on the next status read and on `irq` one cycle after the clear strobe. Lane-enable mistakes show up as corrupted neighbour bytes on a later read, so every read is compared against a bench model of both the data and the parity sense of each lane.

// File: rtl/parity_ram.sv
module parity_ram #(
  parameter int LANES = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_lock,
  input  logic [AW-1:0]      req_addr,
  input  logic [LANES-1:0]   req_be,
  input  logic [8*LANES-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [8*LANES-1:0] rsp_rdata,
  output logic               rsp_err,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int CW = LANES + 5;
  localparam int WW = 9 * LANES;
  localparam int NW = $clog2(LANES + 1);

  logic [WW-1:0]    mem [DEPTH];
  logic [WW-1:0]    rd_q;
  logic [CW-1:0]    ctrl;
  logic [2:0]       sticky, stat_view, clr, ev;
  logic [LANES-1:0] lane_bad;
  logic [NW-1:0]    bad_cnt;

  wire [LANES-1:0] odd_sel  = ctrl[LANES-1:0];
  wire chk_off   = ctrl[LANES];
  wire rsp_en    = ctrl[LANES+1];
  wire [2:0] irq_en = ctrl[LANES+4:LANES+2];

  always_ff @(posedge clk) begin
    if (req_valid && req_write)
      for (int i = 0; i < LANES; i++)
        if (req_be[i])
          mem[req_addr][9*i +: 9] <= {^req_wdata[8*i +: 8] ^ odd_sel[i], req_wdata[8*i +: 8]};
    if (req_valid && !req_write) rd_q <= mem[req_addr];
  end

  always_ff @(posedge clk)
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid && !req_write;

  always_comb begin
    bad_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      rsp_rdata[8*i +: 8] = rd_q[9*i +: 8];
      lane_bad[i] = ^rd_q[9*i +: 9];
      bad_cnt = bad_cnt + NW'(lane_bad[i]);
    end
  end

  wire chk_on = rsp_valid && !chk_off;
  assign ev[0] = chk_on && bad_cnt == NW'(1);
  assign ev[1] = chk_on && bad_cnt > NW'(1);
  assign ev[2] = req_valid && req_lock;
  assign rsp_err   = chk_on && rsp_en && |lane_bad;
  assign stat_view = sticky | {1'b0, ev[1:0]};
  assign irq       = |(stat_view & irq_en);
  assign clr       = (reg_wr && reg_sel) ? reg_wdata[2:0] : 3'b000;
  assign reg_rdata = reg_sel ? {29'b0, stat_view} : {{(32-CW){1'b0}}, ctrl};

  always_ff @(posedge clk)
    if (!rst_n) begin
      ctrl   <= '0;
      sticky <= '0;
    end else begin
      if (reg_wr && !reg_sel) ctrl <= reg_wdata[CW-1:0];
      sticky <= (sticky & ~clr) | ev;
    end

  // R1
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R1
  no_rsp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R4
  chk_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && chk_off) |-> (!rsp_err && stat_view[1:0] == sticky[1:0]));
  // R5
  err_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_en));
  // R7
  lock_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lock) |=> sticky[2]);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[0] && !(reg_wr && reg_sel && reg_wdata[0])) |=> sticky[0]);
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[1] && irq_en[1]) |-> irq);
endmodule

// File: tb/sim_parity_ram.sv
`timescale 1ns/1ps
module sim_parity_ram;
  localparam int L = 16, D = 64, AW = 6;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_lock = 0;
  logic [AW-1:0] req_addr = '0;
  logic [L-1:0] req_be = '0;
  logic [8*L-1:0] req_wdata = '0;
  logic rsp_valid, rsp_err, irq;
  logic [8*L-1:0] rsp_rdata;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int checks = 0, errors = 0;
  logic [8*L-1:0] mdata [D];
  logic [L-1:0]   modd  [D];
  logic [20:0]    cfg = '0;

  always #2.5 clk = ~clk;

  parity_ram #(.LANES(L), .DEPTH(D)) u0 (.*);

  task automatic check(string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(logic [L-1:0] odd, logic lk);
    int n = $countones(odd);
    logic on = !cfg[16];
    return {lk, on && n > 1, on && n == 1};
  endfunction

  function automatic logic exp_irq(logic [2:0] s);
    return |(s & cfg[20:18]);
  endfunction

  task automatic set_ctrl(logic [31:0] v);
    reg_sel = 0; reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0; #1;
    cfg = v[20:0];
    check("R9 ctrl readback", reg_rdata, {11'b0, v[20:0]});
  endtask

  task automatic clear_stat();
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h7;
    @(negedge clk); reg_wr = 0; #1;
    check("R8 status cleared", reg_rdata, 0);
    check("R6 irq after clear", irq, 0);
  endtask

  task automatic wr(int a, logic [127:0] d, logic [L-1:0] be, logic lk);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_be = be;
    req_wdata = d; req_lock = lk;
    @(negedge clk); req_valid = 0; req_lock = 0; reg_sel = 1; #1;
    for (int i = 0; i < L; i++)
      if (be[i]) begin
        mdata[a][8*i +: 8] = d[8*i +: 8];
        modd[a][i] = cfg[i];
      end
    check("R1 no rsp on write", rsp_valid, 0);
    check("R7 lock on write", reg_rdata, {29'b0, lk, 2'b0});
    check("R6 irq on write", irq, lk & cfg[20]);
    if (lk) clear_stat();
  endtask

  task automatic rd(int a, logic lk);
    logic [2:0] s;
    req_valid = 1; req_write = 0; req_addr = AW'(a); req_lock = lk;
    @(negedge clk); req_valid = 0; req_lock = 0; reg_sel = 1; #1;
    s = exp_stat(modd[a], lk);
    check("R1 rsp_valid", rsp_valid, 1);
    check("R1 rdata", rsp_rdata, mdata[a]);
    check("R3 R10 status", reg_rdata, {29'b0, s});
    check("R5 rsp_err", rsp_err, cfg[17] && !cfg[16] && modd[a] != 0);
    check("R6 irq", irq, exp_irq(s));
    if (s != 0) begin
      @(negedge clk); #1;
      check("R8 sticky held", reg_rdata, {29'b0, s});
      check("R6 irq held", irq, exp_irq(s));
      clear_stat();
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R9 reset state
    reg_sel = 0; #0.1; check("R9 ctrl reset", reg_rdata, 0);
    reg_sel = 1; #0.1; check("R9 status reset", reg_rdata, 0);
    check("R9 irq reset", irq, 0);
    check("R9 rsp_valid reset", rsp_valid, 0);
    set_ctrl(32'hFFFF_FFFF);
    set_ctrl(32'h0);
    for (int a = 0; a < D; a++) wr(a, {$urandom, $urandom, $urandom, $urandom}, '1, 0);
    rd(3, 0);
    // R2 R3 single injected error, no enables: still logged
    set_ctrl(32'h0000_0001); wr(5, 128'h1234, '1, 0);
    set_ctrl(32'h0); rd(5, 0);
    // R3 R5 R6 multi error with response and irq enables
    set_ctrl(32'h0000_8001); wr(6, ~128'h0, '1, 0);
    set_ctrl(32'h000A_0000); rd(6, 0);
    // R6 single irq enable
    set_ctrl(32'h0004_0000); rd(5, 0);
    // R4 checking disabled
    set_ctrl(32'h001F_0000); rd(6, 0); rd(5, 0);
    // R7 lock while disabled
    rd(7, 1);
    // R1 partial lane write: only lane 3 rewritten with odd parity
    set_ctrl(32'h0000_FFFF); wr(8, {16{8'hA5}}, 16'h0008, 0);
    set_ctrl(32'h001E_0000); rd(8, 0);
    // R8 set beats clear in same cycle
    req_valid = 1; req_write = 0; req_addr = 0; req_lock = 1;
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h4;
    @(negedge clk); req_valid = 0; req_lock = 0; reg_wr = 0; #1;
    check("R8 set wins", reg_rdata[2], 1);
    clear_stat();
    // random phase
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 9);
      int a = $urandom_range(0, D - 1);
      logic lk = ($urandom_range(0, 7) == 0);
      if (op == 0) set_ctrl($urandom);
      else if (op < 5) wr(a, {$urandom, $urandom, $urandom, $urandom}, L'($urandom), lk);
      else rd(a, lk);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule